// File: doc/BRIEF.md
# Compare Match Timer with Read-Armed Status Flags

This block is an up-counter that is compared against a programmable constant. Software reaches it through a small register port. A prescaler, picked by a clock-select field, turns the system clock into a count-enable pulse. Each enabled count can raise a match flag, when the new count equals the constant, or an overflow flag, when the count wraps to zero at the selected width. A set match flag can drive an interrupt request or a DMA request, chosen by a two-bit field.

The status flags are hard to clear by accident. A write of 0 clears a flag only if an earlier read of the status register returned that flag as 1, and nothing can set a flag from the bus. In one-shot mode the counter returns to zero at the match and stops there. It starts again only after software has cleared the match flag. In free-running mode the count carries on past the match and wraps. While the counter runs, the configuration fields are locked.

The register map uses a two-bit address:
- 0 is status/control.
- 1 is the start register (bit 0 = run).
- 2 is the counter.
- 3 is the compare constant.

Top module: `match_timer`

## Requirements
- R1: After reset, every status/control bit, the run bit and the counter read 0, and both request outputs are low. Status bits 13:10, 7:6, 3 and 31:16 always read 0.
- R2: The match flag (status bit 15) is set on a count step whose new counter value equals the compare constant, masked to the selected width.
- R3: The overflow flag (status bit 14) is set when a count step wraps the counter to 0. The counter is 32 bits wide when bit 9 is 0 and 16 bits wide when bit 9 is 1, so a 16-bit count passes 0xFFFF without overflow in 32-bit mode.
- R4: Writing 1 to bit 15 or bit 14 never sets the flag and leaves it unchanged.
- R5: A flag clears only on a write of 0 to its bit, and only after a read of address 0 has returned that flag as 1. A write of 0 with no such read leaves it set. Any write to address 0 consumes the arming.
- R6: If a flag is set again after the arming read and before the write, the arming is discarded and the write of 0 leaves the flag set.
- R7: With bit 8 = 1 (one-shot), the counter is cleared to 0 at the match and holds there while the match flag is set. Counting resumes once that flag has been cleared.
- R8: While run = 1, writes to bits 9, 8, 5:4 and 2:0 are ignored. The flags can still be cleared.
- R9: Bits 5:4 select the request for a set match flag: 01 drives dmaReq, 10 drives irqReq, and 00 and 11 drive neither.
- R10: Bits 2:0 select a count step every 8, 32, 128 or 512 cycles for codes 0 to 3, counted from the cycle run was set. Codes 4 to 7 never count.
- R11: When a flag-set event and an armed clearing write fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (arms flag clearing) |
| regAddr | input | 2 | Register address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| irqReq | output | 1 | Interrupt request level |
| dmaReq | output | 1 | DMA transfer request level |

## Verification
The two functions that can share a cycle are a flag-set event from the counter and the software write that clears the flag.

The bench fixes the prescaler phase by starting the run from a known edge. It then:
- arms the flag with a read;
- rewinds the counter so the next count step produces a match;
- places the clearing write on exactly that step's edge.

The flag must read back as 1 afterwards. The same setup with the write one cycle later shows the separate rule that a re-set discards the arming. A final armed write, away from any count step, shows the flag does clear.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
  localparam int unsigned DATA_W = 32;

  // register addresses
  typedef enum logic [1:0] {
    ADDR_STAT = 2'd0,
    ADDR_RUN  = 2'd1,
    ADDR_CNT  = 2'd2,
    ADDR_CMP  = 2'd3
  } regSel_e;

  // status/control bit positions
  localparam int unsigned BIT_CMF    = 15;
  localparam int unsigned BIT_OVF    = 14;
  localparam int unsigned BIT_NARROW = 9;
  localparam int unsigned BIT_ONESHOT = 8;
  localparam int unsigned REQ_LSB    = 4;
  localparam int unsigned SEL_LSB    = 0;

  // control-to-datapath strobes
  typedef struct packed {
    logic              run;
    logic [2:0]        clkSel;
    logic              narrow;
    logic              oneShot;
    logic              halt;
    logic              cntWr;
    logic              cmpWr;
    logic [DATA_W-1:0] wrData;
  } dpStrobe_t;
endpackage

// File: rtl/match_timer_flag.sv
module match_timer_flag (
  input  logic clk,
  input  logic rstN,
  input  logic setEv,
  input  logic rdStat,
  input  logic wrStat,
  input  logic wrBit,
  output logic flagQ
);
  logic armQ;

  // arming: taken by a read that sees the flag high, lost on re-set or any write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armQ <= 1'b0;
    end else if (setEv || wrStat) begin
      armQ <= 1'b0;
    end else if (rdStat && flagQ) begin
      armQ <= 1'b1;
    end
  end

  // set has priority over the clearing write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (setEv) begin
      flagQ <= 1'b1;
    end else if (wrStat && !wrBit && armQ) begin
      flagQ <= 1'b0;
    end
  end

  // R5
  flag_clear_needs_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagQ) |-> $past(wrStat && !wrBit && armQ));

  // R11
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    setEv |=> flagQ);

  // R4
  flag_rise_only_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(setEv));
endmodule

// File: rtl/match_timer_dp.sv
module match_timer_dp
  import match_timer_pkg::*;
#(
  parameter int unsigned NARROW_W     = 16,
  parameter int unsigned DIV_BASE_LOG = 3,
  parameter int unsigned DIV_STEP_LOG = 2,
  parameter int unsigned NUM_DIV      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         ctl,
  output logic              matchEv,
  output logic              ovfEv,
  output logic [DATA_W-1:0] cntVal,
  output logic [DATA_W-1:0] cmpVal
);
  localparam int unsigned PRE_W = DIV_BASE_LOG + DIV_STEP_LOG * (NUM_DIV - 1);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
  localparam logic [DATA_W-1:0] NARROW_MASK =
    {{(DATA_W - NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [PRE_W-1:0]   preQ;
  logic [NUM_DIV-1:0] tickVec;
  logic               tick;
  logic               countEn;
  logic [DATA_W-1:0]  cntQ, cmpQ, widthMask, cntInc;
  logic               wrapHit, matchHit;

  // prescaler restarts whenever counting is stopped
  always_ff @(posedge clk) begin
    if (!rstN || !ctl.run) begin
      preQ <= '0;
    end else begin
      preQ <= preQ + PRE_W'(1);
    end
  end

  for (genvar gi = 0; gi < NUM_DIV; gi++) begin : g_tap
    assign tickVec[gi] = &preQ[DIV_BASE_LOG + DIV_STEP_LOG * gi - 1 : 0];
  end

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NUM_DIV; i++) begin
      if (ctl.clkSel == 3'(i)) tick = tickVec[i];
    end
  end

  assign countEn   = ctl.run && tick && !ctl.halt;
  assign widthMask = ctl.narrow ? NARROW_MASK : '1;
  assign cntInc    = (cntQ + ONE) & widthMask;
  assign wrapHit   = (cntQ & widthMask) == widthMask;
  assign matchHit  = cntInc == (cmpQ & widthMask);
  assign matchEv   = countEn && matchHit;
  assign ovfEv     = countEn && wrapHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (ctl.cntWr) begin
      cntQ <= ctl.wrData & widthMask;
    end else if (countEn) begin
      cntQ <= (matchHit && ctl.oneShot) ? '0 : cntInc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpQ <= '0;
    end else if (ctl.cmpWr) begin
      cmpQ <= ctl.wrData;
    end
  end

  assign cntVal = cntQ;
  assign cmpVal = cmpQ;

  // R7
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.halt && !ctl.cntWr) |=> $stable(cntQ));

  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfEv && !ctl.cntWr) |=> (cntQ == '0));

  // R10
  reserved_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((ctl.clkSel >= 3'(NUM_DIV)) && !ctl.cntWr) |=> $stable(cntQ));
endmodule

// File: rtl/match_timer_ctrl.sv
module match_timer_ctrl
  import match_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqReq,
  output logic              dmaReq,
  input  logic              matchEv,
  input  logic              ovfEv,
  input  logic [DATA_W-1:0] cntVal,
  input  logic [DATA_W-1:0] cmpVal,
  output dpStrobe_t         ctl
);
  localparam int unsigned NUM_FLAGS = 2;

  regSel_e        sel;
  logic           wrStat, rdStat, wrRun;
  logic           runQ, narrowQ, oneShotQ;
  logic [1:0]     reqSelQ;
  logic [2:0]     clkSelQ;
  logic [NUM_FLAGS-1:0] flagSet, flagQ;
  logic           cmfQ, ovfQ;
  logic [15:0]    statusWord;

  assign sel    = regSel_e'(regAddr);
  assign wrStat = regWrEn && (sel == ADDR_STAT);
  assign rdStat = regRdEn && (sel == ADDR_STAT);
  assign wrRun  = regWrEn && (sel == ADDR_RUN);

  // index 1 = match flag, index 0 = overflow flag
  assign flagSet = {matchEv, ovfEv};

  for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
    match_timer_flag u_flag (
      .clk    (clk),
      .rstN   (rstN),
      .setEv  (flagSet[gi]),
      .rdStat (rdStat),
      .wrStat (wrStat),
      .wrBit  (regWrData[BIT_OVF + gi]),
      .flagQ  (flagQ[gi])
    );
  end

  assign cmfQ = flagQ[1];
  assign ovfQ = flagQ[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ <= 1'b0;
    end else if (wrRun) begin
      runQ <= regWrData[0];
    end
  end

  // configuration accepted only while stopped
  always_ff @(posedge clk) begin
    if (!rstN) begin
      narrowQ  <= 1'b0;
      oneShotQ <= 1'b0;
      reqSelQ  <= 2'b00;
      clkSelQ  <= 3'b000;
    end else if (wrStat && !runQ) begin
      narrowQ  <= regWrData[BIT_NARROW];
      oneShotQ <= regWrData[BIT_ONESHOT];
      reqSelQ  <= regWrData[REQ_LSB +: 2];
      clkSelQ  <= regWrData[SEL_LSB +: 3];
    end
  end

  assign statusWord = {cmfQ, ovfQ, 4'b0000, narrowQ, oneShotQ, 2'b00,
                       reqSelQ, 1'b0, clkSelQ};

  always_comb begin
    unique case (sel)
      ADDR_STAT: regRdData = {16'h0000, statusWord};
      ADDR_RUN:  regRdData = {{(DATA_W-1){1'b0}}, runQ};
      ADDR_CNT:  regRdData = cntVal;
      default:   regRdData = cmpVal;
    endcase
  end

  assign irqReq = cmfQ && (reqSelQ == 2'b10);
  assign dmaReq = cmfQ && (reqSelQ == 2'b01);

  always_comb begin
    ctl.run     = runQ;
    ctl.clkSel  = clkSelQ;
    ctl.narrow  = narrowQ;
    ctl.oneShot = oneShotQ;
    ctl.halt    = oneShotQ && cmfQ;
    ctl.cntWr   = regWrEn && (sel == ADDR_CNT);
    ctl.cmpWr   = regWrEn && (sel == ADDR_CMP);
    ctl.wrData  = regWrData;
  end

  // R8
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    runQ |=> $stable({narrowQ, oneShotQ, reqSelQ, clkSelQ}));

  // R9
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({irqReq, dmaReq}));

  // R2
  match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchEv |=> cmfQ);
endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int unsigned NARROW_W     = 16,
  parameter int unsigned DIV_BASE_LOG = 3,
  parameter int unsigned DIV_STEP_LOG = 2,
  parameter int unsigned NUM_DIV      = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        irqReq,
  output logic        dmaReq
);
  dpStrobe_t         ctl;
  logic              matchEv, ovfEv;
  logic [DATA_W-1:0] cntVal, cmpVal;

  match_timer_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqReq    (irqReq),
    .dmaReq    (dmaReq),
    .matchEv   (matchEv),
    .ovfEv     (ovfEv),
    .cntVal    (cntVal),
    .cmpVal    (cmpVal),
    .ctl       (ctl)
  );

  match_timer_dp #(
    .NARROW_W     (NARROW_W),
    .DIV_BASE_LOG (DIV_BASE_LOG),
    .DIV_STEP_LOG (DIV_STEP_LOG),
    .NUM_DIV      (NUM_DIV)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .matchEv (matchEv),
    .ovfEv   (ovfEv),
    .cntVal  (cntVal),
    .cmpVal  (cmpVal)
  );
endmodule

// File: tb/match_timer_tb.sv
module match_timer_tb;
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_RUN  = 2'd1;
  localparam logic [1:0] A_CNT  = 2'd2;
  localparam logic [1:0] A_CMP  = 2'd3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqReq, dmaReq;
  int          total = 0;
  int          fails = 0;

  always #4 clk = ~clk;

  match_timer u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqReq(irqReq), .dmaReq(dmaReq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // each access consumes exactly one rising edge, starting and ending at a falling edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stopClear(input logic [31:0] cfg, input logic [31:0] cmp);
    logic [31:0] tmp;
    wr(A_RUN, 0);
    rd(A_STAT, tmp);
    wr(A_STAT, cfg);
    wr(A_CNT, 0);
    wr(A_CMP, cmp);
  endtask

  task automatic testReset();
    logic [31:0] v;
    rd(A_STAT, v); check("R1 status after reset", v, 32'h0);
    rd(A_RUN, v);  check("R1 run after reset", v, 32'h0);
    rd(A_CNT, v);  check("R1 counter after reset", v, 32'h0);
    check("R1 requests after reset", {30'h0, irqReq, dmaReq}, 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); check("R1 R4 reserved zero, flags not set by 1", v, 32'h0000_0337);
    wr(A_STAT, 32'h0);
  endtask

  task automatic testMatchClear();
    logic [31:0] v;
    stopClear(32'h0020, 32'd3);
    wr(A_RUN, 1);
    idle(28);
    check("R2 match raises irq", {31'h0, irqReq}, 32'h1);
    wr(A_STAT, 32'hC020);
    check("R4 write 1 keeps flag", {31'h0, irqReq}, 32'h1);
    wr(A_STAT, 32'h0020);
    check("R5 unarmed write 0 keeps flag", {31'h0, irqReq}, 32'h1);
    rd(A_STAT, v); check("R4 overflow not set by write 1", v, 32'h0000_8020);
    wr(A_STAT, 32'h0020);
    rd(A_STAT, v); check("R5 armed write 0 clears", v, 32'h0000_0020);
    check("R5 irq drops after clear", {31'h0, irqReq}, 32'h0);
  endtask

  task automatic testDiscard();
    logic [31:0] v;
    stopClear(32'h0, 32'd1);
    wr(A_RUN, 1);
    idle(8);
    rd(A_STAT, v); check("R6 flag set before arm", v, 32'h0000_8000);
    wr(A_CNT, 0);
    idle(6);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); check("R6 re-set discards arming", v, 32'h0000_8000);
  endtask

  task automatic testSameCycle();
    logic [31:0] v;
    stopClear(32'h0, 32'd1);
    wr(A_RUN, 1);
    idle(8);
    rd(A_STAT, v);
    wr(A_CNT, 0);
    idle(5);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); check("R11 set beats same-cycle clear", v, 32'h0000_8000);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); check("R5 later armed clear works", v, 32'h0);
  endtask

  task automatic testOverflow();
    logic [31:0] v;
    stopClear(32'h0200, 32'h1234);
    wr(A_CNT, 32'h0000_FFFE);
    wr(A_RUN, 1);
    idle(20);
    rd(A_CNT, v);  check("R3 16-bit wrap to zero", v, 32'h0);
    rd(A_STAT, v); check("R3 16-bit overflow flag", v, 32'h0000_4200);
    stopClear(32'h0, 32'h1234);
    wr(A_CNT, 32'hFFFF_FFFE);
    wr(A_RUN, 1);
    idle(20);
    rd(A_CNT, v);  check("R3 32-bit wrap to zero", v, 32'h0);
    rd(A_STAT, v); check("R3 32-bit overflow flag", v, 32'h0000_4000);
    stopClear(32'h0, 32'h1234);
    wr(A_CNT, 32'h0000_FFFE);
    wr(A_RUN, 1);
    idle(20);
    rd(A_CNT, v);  check("R3 32-bit passes 0xFFFF", v, 32'h0001_0000);
    rd(A_STAT, v); check("R3 no overflow at 16 bits in 32-bit mode", v, 32'h0);
  endtask

  task automatic testOneShot();
    logic [31:0] v;
    stopClear(32'h0100, 32'd2);
    wr(A_RUN, 1);
    idle(40);
    rd(A_CNT, v);  check("R7 one-shot holds at zero", v, 32'h0);
    rd(A_STAT, v); check("R7 match flag in one-shot", v, 32'h0000_8100);
    wr(A_STAT, 32'h0100);
    idle(10);
    rd(A_CNT, v);  check("R7 counting resumes after clear", v, 32'h1);
    rd(A_STAT, v); check("R8 flag clearable while running", v, 32'h0000_0100);
  endtask

  task automatic testLock();
    logic [31:0] v;
    stopClear(32'h0, 32'h100);
    wr(A_RUN, 1);
    wr(A_STAT, 32'h0000_0337);
    rd(A_STAT, v); check("R8 config write ignored while running", v, 32'h0);
    wr(A_RUN, 0);
    rd(A_STAT, v); check("R8 config unchanged after stop", v, 32'h0);
  endtask

  task automatic testRequest();
    stopClear(32'h0, 32'd1);
    wr(A_RUN, 1);
    idle(12);
    wr(A_RUN, 0);
    for (int code = 0; code < 4; code++) begin
      logic [1:0] expReq;
      wr(A_STAT, 32'h8000 | (32'(code) << 4));
      expReq = (code == 2) ? 2'b10 : (code == 1) ? 2'b01 : 2'b00;
      check($sformatf("R9 request select %0d", code), {30'h0, irqReq, dmaReq}, {30'h0, expReq});
    end
    stopClear(32'h0020, 32'd1);
    check("R9 no irq without flag", {31'h0, irqReq}, 32'h0);
  endtask

  task automatic testPrescale();
    logic [31:0] v;
    for (int c = 0; c < 4; c++) begin
      int d;
      d = 8 << (2 * c);
      stopClear(32'(c), 32'hFFFF_FFFF);
      wr(A_RUN, 1);
      idle(3 * d + d / 2);
      rd(A_CNT, v);
      check($sformatf("R10 divide code %0d", c), v, 32'd3);
    end
    stopClear(32'd5, 32'hFFFF_FFFF);
    wr(A_RUN, 1);
    idle(100);
    rd(A_CNT, v); check("R10 reserved code does not count", v, 32'h0);
    wr(A_RUN, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMatchClear();
    testDiscard();
    testSameCycle();
    testOverflow();
    testOneShot();
    testLock();
    testRequest();
    testPrescale();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule